// File: doc/BRIEF.md
# Overcurrent Hiccup Sequencer for a Linear Regulator

This block is the digital fault sequencer that sits beside a linear regulator's current-sense comparator. It watches a raw overcurrent flag, which goes high when the voltage across the sense element reaches its 50 mV trip point, and decides whether the regulator stays on, runs in current limit, or is switched off. When an overload first appears, the regulator stays on in current limit for a fixed window (10 ms by default). If the overload is still there when that window closes, the regulator is turned off for a longer cool-down (100 ms by default). After the cool-down it is powered up again for another 10 ms trial. This off-and-retry cycle repeats for as long as the overload lasts. If the overload goes away during a limit window or a trial, the block goes back to normal operation and clears its fault output.

Time is measured in milliseconds. A millisecond is a parameterized number of cycles on which the `ms_tick` strobe input is high. Tie the strobe high to count plain clock cycles, or drive it from a slower time base. A low enable forces the block off from any state and clears every timer. The current state is brought out on a port for test.

Top module: `ocp_hiccup_ctrl`

## Requirements
- R1: While `rst_n` is low and after reset, `state_o` is IDLE (0) and `reg_on`, `limit_active` and `fault` are 0.
- R2: If `en` is low at a clock edge, `state_o` is IDLE (0) after that edge from any state, and every timer restarts. If `en` is high at an edge while in IDLE, the state is ON (1) after that edge.
- R3: `oc_raw` passes through two synchronizer flops and must then be high on two consecutive samples. A single-cycle pulse on `oc_raw` leaves the block in ON. A sustained high moves ON to LIMIT (2) on the third clock edge after the edge that first samples it high.
- R4: In LIMIT, `reg_on`=1, `limit_active`=1 and `fault`=1. With the overload held, LIMIT lasts exactly LIMIT_MS×TICKS_PER_MS cycles that have `ms_tick` high, and then the state moves to OFF_WAIT (3).
- R5: If the confirmed overload clears in LIMIT or RETRY, the state is ON on the second edge after the edge that first samples `oc_raw` low, and `fault` is then 0.
- R6: In OFF_WAIT, `reg_on`=0, `limit_active`=0 and `fault`=1. OFF_WAIT ignores `oc_raw`, lasts exactly RETRY_MS×TICKS_PER_MS strobe cycles, and then moves to RETRY (4).
- R7: In RETRY, `reg_on`=1, `limit_active`=1 and `fault`=1. With the overload held, RETRY lasts LIMIT_MS×TICKS_PER_MS strobe cycles and then returns to OFF_WAIT. The cycle repeats without limit.
- R8: Timers advance only on cycles with `ms_tick` high. A timed state with the strobe held low never expires.
- R9: `state_o` encodes IDLE=0, ON=1, LIMIT=2, OFF_WAIT=3, RETRY=4 and follows the transition rules above for any input sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Regulator enable; low forces the off state |
| oc_raw | input | 1 | Asynchronous overcurrent comparator flag |
| ms_tick | input | 1 | Time-base strobe; TICKS_PER_MS strobes make one millisecond |
| reg_on | output | 1 | Regulator pass device on |
| limit_active | output | 1 | Regulator in current-limit mode |
| fault | output | 1 | Overload being handled (limit, off or retry) |
| state_o | output | 3 | Current sequencer state for test |

## Verification
Each result has its own latency. A change of state appears one edge after the inputs that cause it. A new overload reaches the state on the third edge after it is first sampled, and a cleared overload on the second. A timed window ends exactly when its last counted strobe has been seen. The bench drives inputs on the falling edge, advances past one rising edge, and samples on the next falling edge. Directed checks are placed on the exact step on which each edge count says the change is due, and window lengths are measured in those steps. During the random phase, a cycle-level reference model built from these latency rules is stepped on the same edges and compared with every output after every step.

// File: rtl/ocp_pkg.sv
// Shared types for the overcurrent hiccup sequencer.
// Assumes: a state fits in three bits and the codes are fixed for test.
package ocp_pkg;
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_ON      = 3'd1,
        ST_LIMIT   = 3'd2,
        ST_OFFWAIT = 3'd3,
        ST_RETRY   = 3'd4
    } ocp_state_e;
endpackage

// File: rtl/ocp_oc_filter.sv
// Overcurrent flag conditioner: a synchronizer chain followed by a
// two-sample confirmation, so that a one-cycle glitch is never accepted.
// Assumes: oc_raw is asynchronous to clk; SYNC_STAGES >= 2.
module ocp_oc_filter #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic oc_raw,
    output logic oc_q
);
    logic [SYNC_STAGES:0] chain;

    // Shift the raw flag through the sync stages plus one confirm stage.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[SYNC_STAGES-1:0], oc_raw};
    end

    // Confirmed only when the last two samples are both high.
    assign oc_q = chain[SYNC_STAGES] & chain[SYNC_STAGES-1];
endmodule

// File: rtl/ocp_timebase.sv
// Millisecond prescaler: counts strobe cycles and emits one tick per
// TICKS_PER_MS strobes; restarts at phase zero when the sequencer changes state.
// Assumes: TICKS_PER_MS >= 1.
module ocp_timebase #(
    parameter int TICKS_PER_MS = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    input  logic restart,
    output logic ms_tick
);
    localparam int PW = (TICKS_PER_MS > 1) ? $clog2(TICKS_PER_MS) : 1;
    localparam logic [PW-1:0] PLAST = PW'(TICKS_PER_MS - 1);

    logic [PW-1:0] presc;

    assign ms_tick = strobe && (presc == PLAST);

    // Advance the phase on each strobe, wrapping at the millisecond boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)       presc <= '0;
        else if (restart) presc <= '0;
        else if (strobe)  presc <= (presc == PLAST) ? '0 : presc + 1'b1;
    end
endmodule

// File: rtl/ocp_fsm.sv
// Hiccup state machine: ON -> LIMIT on a confirmed overload, LIMIT/RETRY ->
// OFF_WAIT when the window expires under overload, OFF_WAIT -> RETRY after
// the cool-down. A low enable wins over everything.
// Assumes: ms_tick is one cycle per elapsed millisecond; windows >= 1 ms.
module ocp_fsm
    import ocp_pkg::*;
#(
    parameter int LIMIT_MS = 10,
    parameter int RETRY_MS = 100
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       oc_q,
    input  logic       ms_tick,
    output ocp_state_e state,
    output logic       restart
);
    localparam int MAXW = (RETRY_MS > LIMIT_MS) ? RETRY_MS : LIMIT_MS;
    localparam int CW   = $clog2(MAXW + 1);

    ocp_state_e    st_nxt;
    logic [CW-1:0] ms_cnt;
    logic [CW-1:0] win_last;
    logic          timed;
    logic          done;

    assign timed = (state == ST_LIMIT) || (state == ST_OFFWAIT) || (state == ST_RETRY);

    // Select the final millisecond index of the current window.
    always_comb begin
        win_last = (state == ST_OFFWAIT) ? CW'(RETRY_MS - 1) : CW'(LIMIT_MS - 1);
    end

    assign done = ms_tick && (ms_cnt == win_last);

    // Next-state decision; enable low has top priority.
    always_comb begin
        st_nxt = state;
        if (!en) begin
            st_nxt = ST_IDLE;
        end else begin
            case (state)
                ST_IDLE:    st_nxt = ST_ON;
                ST_ON:      if (oc_q) st_nxt = ST_LIMIT;
                ST_LIMIT,
                ST_RETRY:   if (!oc_q) st_nxt = ST_ON;
                            else if (done) st_nxt = ST_OFFWAIT;
                ST_OFFWAIT: if (done) st_nxt = ST_RETRY;
                default:    st_nxt = ST_IDLE;
            endcase
        end
    end

    assign restart = (st_nxt != state);

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= st_nxt;
    end

    // Millisecond counter for the timed states; cleared on every transition.
    always_ff @(posedge clk) begin
        if (!rst_n)                ms_cnt <= '0;
        else if (restart)          ms_cnt <= '0;
        else if (ms_tick && timed) ms_cnt <= ms_cnt + 1'b1;
    end
endmodule

// File: rtl/ocp_hiccup_ctrl.sv
// Top level of the overcurrent hiccup sequencer: conditions the comparator
// flag, derives milliseconds from the strobe and runs the retry state machine.
// Assumes: synchronous active-low reset; ms_tick is synchronous to clk.
module ocp_hiccup_ctrl
    import ocp_pkg::*;
#(
    parameter int LIMIT_MS     = 10,
    parameter int RETRY_MS     = 100,
    parameter int TICKS_PER_MS = 1,
    parameter int SYNC_STAGES  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       oc_raw,
    input  logic       ms_tick,
    output logic       reg_on,
    output logic       limit_active,
    output logic       fault,
    output logic [2:0] state_o
);
    logic       oc_q;
    logic       ms_pulse;
    logic       restart;
    ocp_state_e state;

    ocp_oc_filter #(.SYNC_STAGES(SYNC_STAGES)) i_filter (
        .clk(clk), .rst_n(rst_n), .oc_raw(oc_raw), .oc_q(oc_q)
    );

    ocp_timebase #(.TICKS_PER_MS(TICKS_PER_MS)) i_timebase (
        .clk(clk), .rst_n(rst_n), .strobe(ms_tick), .restart(restart), .ms_tick(ms_pulse)
    );

    ocp_fsm #(.LIMIT_MS(LIMIT_MS), .RETRY_MS(RETRY_MS)) i_fsm (
        .clk(clk), .rst_n(rst_n), .en(en), .oc_q(oc_q), .ms_tick(ms_pulse),
        .state(state), .restart(restart)
    );

    // Output decode from the state register.
    always_comb begin
        reg_on       = (state == ST_ON) || (state == ST_LIMIT) || (state == ST_RETRY);
        limit_active = (state == ST_LIMIT) || (state == ST_RETRY);
        fault        = (state == ST_LIMIT) || (state == ST_OFFWAIT) || (state == ST_RETRY);
        state_o      = state;
    end
endmodule

// File: rtl/ocp_hiccup_chk.sv
// Checker for the hiccup sequencer: watches port-level state changes and
// counts strobes per state residency to confirm window lengths.
// Assumes: bound to ocp_hiccup_ctrl, which has an internal signal oc_q.
module ocp_hiccup_chk #(
    parameter int LIMIT_MS     = 10,
    parameter int RETRY_MS     = 100,
    parameter int TICKS_PER_MS = 1
) (
    input logic       clk,
    input logic       rst_n,
    input logic       en,
    input logic       ms_tick,
    input logic       oc_q,
    input logic       fault,
    input logic [2:0] state_o
);
    localparam int LIM_STROBES = LIMIT_MS * TICKS_PER_MS;
    localparam int OFF_STROBES = RETRY_MS * TICKS_PER_MS;

    logic [2:0] st_q;
    int         cnt;

    // Remember the previous state and count strobes in its current run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= 3'd0;
            cnt  <= 0;
        end else begin
            st_q <= state_o;
            cnt  <= (state_o != st_q) ? int'(ms_tick) : cnt + int'(ms_tick);
        end
    end

    a_r2_disable_forces_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (state_o == 3'd0));

    a_r3_limit_needs_overload: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd2 && st_q != 3'd2) |-> (st_q == 3'd1 && $past(oc_q)));

    a_r4_limit_window_length: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd3 && st_q != 3'd3) |-> ((st_q == 3'd2 || st_q == 3'd4) && cnt == LIM_STROBES));

    a_r5_clear_returns_on: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd1 && (st_q == 3'd2 || st_q == 3'd4)) |-> (!$past(oc_q) && !fault));

    a_r6_offwait_length: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd4 && st_q != 3'd4) |-> (st_q == 3'd3 && cnt == OFF_STROBES));

    a_r9_state_legal: assert property (@(posedge clk) disable iff (!rst_n)
        state_o <= 3'd4);
endmodule

bind ocp_hiccup_ctrl ocp_hiccup_chk #(
    .LIMIT_MS(LIMIT_MS), .RETRY_MS(RETRY_MS), .TICKS_PER_MS(TICKS_PER_MS)
) i_chk (
    .clk(clk), .rst_n(rst_n), .en(en), .ms_tick(ms_tick),
    .oc_q(oc_q), .fault(fault), .state_o(state_o)
);

// File: tb/test_ocp_hiccup_ctrl.sv
`timescale 1ns/1ps
module test_ocp_hiccup_ctrl;
    localparam int LIM = 10;
    localparam int RET = 100;
    localparam int P   = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic       oc_raw = 1'b0;
    logic       ms_tick = 1'b0;
    logic       reg_on, limit_active, fault;
    logic [2:0] state_o;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    // Reference model state
    int m_st, m_s1, m_s2, m_s3, m_presc, m_cnt;

    always #2.5 clk = ~clk;

    ocp_hiccup_ctrl #(.LIMIT_MS(LIM), .RETRY_MS(RET), .TICKS_PER_MS(P)) i_ocp_hiccup_ctrl (
        .clk(clk), .rst_n(rst_n), .en(en), .oc_raw(oc_raw), .ms_tick(ms_tick),
        .reg_on(reg_on), .limit_active(limit_active), .fault(fault), .state_o(state_o)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: run did not finish, cycle %0d expected < 100000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic chk(input int act, input int exp, input string req);
        n_chk = n_chk + 1;
        if (act != exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_reg_on(input int s);  return (s == 1 || s == 2 || s == 4) ? 1 : 0; endfunction
    function automatic int exp_limit(input int s);   return (s == 2 || s == 4) ? 1 : 0; endfunction
    function automatic int exp_fault(input int s);   return (s == 2 || s == 3 || s == 4) ? 1 : 0; endfunction

    task automatic chk_outs(input int s, input string req);
        chk(int'(state_o), s, req);
        chk(int'(reg_on), exp_reg_on(s), req);
        chk(int'(limit_active), exp_limit(s), req);
        chk(int'(fault), exp_fault(s), req);
    endtask

    function automatic void model_reset();
        m_st = 0; m_s1 = 0; m_s2 = 0; m_s3 = 0; m_presc = 0; m_cnt = 0;
    endfunction

    // One rising edge of the reference model, written from the requirements.
    function automatic void model_edge(input int e, input int o, input int t);
        int occ, tick, len, done, ns;
        occ  = m_s2 & m_s3;
        tick = (t != 0 && m_presc == P - 1) ? 1 : 0;
        len  = (m_st == 3) ? RET : LIM;
        done = (tick != 0 && m_cnt == len - 1) ? 1 : 0;
        ns   = m_st;
        if (e == 0) ns = 0;
        else case (m_st)
            0: ns = 1;
            1: if (occ != 0) ns = 2;
            2, 4: if (occ == 0) ns = 1; else if (done != 0) ns = 3;
            3: if (done != 0) ns = 4;
            default: ns = 0;
        endcase
        if (ns != m_st) begin
            m_presc = 0; m_cnt = 0;
        end else begin
            if (t != 0) m_presc = (m_presc == P - 1) ? 0 : m_presc + 1;
            if (tick != 0 && m_st >= 2) m_cnt = m_cnt + 1;
        end
        m_s3 = m_s2; m_s2 = m_s1; m_s1 = o; m_st = ns;
    endfunction

    // Drive at a falling edge, pass one rising edge, return at the next falling edge.
    task automatic step(input logic e, input logic o, input logic t);
        en = e; oc_raw = o; ms_tick = t;
        @(posedge clk);
        if (rst_n) model_edge(int'(e), int'(o), int'(t));
        @(negedge clk);
    endtask

    task automatic run_until(input int s, input logic o);
        for (int i = 0; i < 1000 && int'(state_o) != s; i++) step(1'b1, o, 1'b1);
    endtask

    // Count cycles spent in the present state with a steady overload and full-rate strobe.
    task automatic measure(input logic o, output int n);
        int s;
        s = int'(state_o);
        n = 1;
        for (int i = 0; i < 1000; i++) begin
            step(1'b1, o, 1'b1);
            if (int'(state_o) != s) break;
            n = n + 1;
        end
    endtask

    initial begin
        int n;
        int hold;
        logic ov;
        void'($urandom(32'd20240611));
        model_reset();
        @(negedge clk);
        step(1'b0, 1'b0, 1'b1);
        step(1'b0, 1'b0, 1'b1);
        chk_outs(0, "R1 reset state");
        rst_n = 1'b1;
        step(1'b0, 1'b0, 1'b1);
        chk_outs(0, "R1 after reset");

        step(1'b1, 1'b0, 1'b1);
        chk_outs(1, "R2 enable enters ON");

        // R3: single-cycle glitch is not accepted
        step(1'b1, 1'b1, 1'b1);
        for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 1'b1);
        chk(int'(state_o), 1, "R3 one-cycle pulse ignored");

        // R3: sustained overload reaches LIMIT on the third edge
        step(1'b1, 1'b1, 1'b1);
        step(1'b1, 1'b1, 1'b1);
        step(1'b1, 1'b1, 1'b1);
        chk(int'(state_o), 1, "R3 still ON after two edges past first sample");
        step(1'b1, 1'b1, 1'b1);
        chk_outs(2, "R3 LIMIT on third edge / R4 outputs");

        measure(1'b1, n);
        chk(n, LIM * P, "R4 limit window length");
        chk_outs(3, "R6 OFF_WAIT outputs");

        // R6: oc_raw toggling during OFF_WAIT has no effect
        n = 1;
        for (int i = 0; i < 150; i++) begin
            step(1'b1, logic'($urandom % 2), 1'b1);
            chk(int'(reg_on), 0, "R6 regulator stays off while waiting");
            if (int'(state_o) == 3) n = n + 1;
        end
        for (int i = 0; i < 100 && int'(state_o) == 3; i++) begin
            step(1'b1, 1'b1, 1'b1);
            if (int'(state_o) == 3) n = n + 1;
        end
        chk(n, RET * P, "R6 off window length with oc_raw ignored");
        chk_outs(4, "R7 RETRY outputs");

        measure(1'b1, n);
        chk(n, LIM * P, "R7 retry window length");
        chk(int'(state_o), 3, "R7 back to OFF_WAIT under overload");
        measure(1'b1, n);
        chk(n, RET * P, "R7 second off window length");
        chk(int'(state_o), 4, "R7 second retry");

        // R5: overload clears during RETRY
        step(1'b1, 1'b0, 1'b1);
        step(1'b1, 1'b0, 1'b1);
        chk(int'(state_o), 4, "R5 still RETRY one edge after first low sample");
        step(1'b1, 1'b0, 1'b1);
        chk_outs(1, "R5 back to ON with fault cleared");

        // R2: disable mid-cool-down, then timers start fresh
        run_until(2, 1'b1);
        run_until(3, 1'b1);
        for (int i = 0; i < 37; i++) step(1'b1, 1'b1, 1'b1);
        step(1'b0, 1'b1, 1'b1);
        chk_outs(0, "R2 disable forces IDLE");
        run_until(2, 1'b1);
        measure(1'b1, n);
        chk(n, LIM * P, "R2 timers restart after re-enable");

        // R8: no strobe, no progress; then strobe every other cycle
        run_until(1, 1'b0);
        run_until(2, 1'b1);
        for (int i = 0; i < 50; i++) step(1'b1, 1'b1, 1'b0);
        chk(int'(state_o), 2, "R8 LIMIT holds without strobes");
        n = 1;
        for (int i = 0; i < 1000; i++) begin
            step(1'b1, 1'b1, logic'(n % 2));
            if (int'(state_o) != 2) break;
            n = n + 1;
        end
        chk(n, 2 * LIM * P - 1, "R8 limit window counts only strobe cycles");

        // R9: random phase against the reference model
        rst_n = 1'b0;
        step(1'b0, 1'b0, 1'b0);
        step(1'b0, 1'b0, 1'b0);
        model_reset();
        rst_n = 1'b1;
        hold = 0;
        ov = 1'b0;
        for (int i = 0; i < 4000; i++) begin
            if (hold == 0) begin
                ov = logic'($urandom % 2);
                hold = int'($urandom % 60);
            end else begin
                hold = hold - 1;
            end
            step(logic'(($urandom % 300) != 0), ov, logic'(($urandom % 4) != 0));
            chk_outs(m_st, "R9 random sequence vs model");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule